// File: doc/BRIEF.md
# Cache Retention Power-Domain Sequencer

This block sequences the power-down and power-up of a processor core whose level-1 data cache RAMs and level-2 cache RAMs can each stay powered in an always-on retention domain. Software asks for a power-down and names which caches keep their contents. The sequencer first raises the hardware-reset-inhibit flag and the input clamp for each retained cache. It then asserts the core reset and turns the core power switch off. On a wake request it restores power, holds reset for a programmable number of cycles after power-good, and releases reset.

Caches that are not retained have their RAM arrays cleared by the hardware reset assist while reset is held. The level-1 instruction cache is always cleared. The clamps on retained RAMs stay on after the core comes back. They are lifted only after software raises a release request, and the sequencer confirms the release with a four-phase handshake. A status word shows the sequencer state, the retained-cache flags and a sticky error bit that records an illegal retention request. Retention-domain state (the flags, the inhibits, the clamps and the error bit) is cleared only by the always-on reset and never by the core power-on reset.

Top module: `retn_pwr_seq`

## Requirements
- R1: After `aon_rst_n` is released, the status state field is RUN (code 0), `pwr_req`=1, `core_rst_n`=1, all inhibit, clamp, clear and ack outputs are 0, and the status bits [6:4] are 0.
- R2: A `pd_req` pulse in RUN with `pd_mode` 0 (no retention), 1 (L2 only) or 2 (L1 data plus L2) moves the state to CLAMP (code 1) on the next cycle. In that cycle the inhibit and clamp outputs of each retained cache are 1, those of the other cache are 0, and `core_rst_n` is still 1.
- R3: CLAMP is followed one cycle later by RESET_ASSERT (code 2) with `core_rst_n`=0, and one cycle after that by POWER_OFF (code 3) with `pwr_req`=0.
- R4: `pd_mode` 3 (L1 data only) is illegal while `L2_ZERO`=0. The request leaves the state in RUN with every inhibit and clamp at 0 and sets the sticky error bit (status bit 6). Later legal requests do not clear that bit. When `L2_ZERO`=1 the mode is legal and retains L1 data only.
- R5: POWER_OFF moves to POWER_ON_WAIT (code 4) with `pwr_req`=1 only when `pwr_ack` is 0 and `wake_req` is 1. POWER_ON_WAIT moves on only after `pwr_ack` is 1.
- R6: After power-good, the state stays in RESET_RELEASE (code 5) for exactly `RST_HOLD` cycles with `core_rst_n`=0. `core_rst_n` returns to 1 on the cycle after.
- R7: During RESET_RELEASE, `l1i_hw_clr` is 1. `l1d_hw_clr` and `l2_hw_clr` are 1 exactly when the matching inhibit is 0. All three are 0 in every other state.
- R8: When reset is released, a sequence with any retained cache enters CLAMPED_RUN (code 6) with its inhibits and clamps still 1. A sequence with no retention returns to RUN.
- R9: In CLAMPED_RUN, a high `unclamp_req` moves the state to UNCLAMP (code 7). In the same cycle both clamps become 0 and `unclamp_ack` becomes 1. When `unclamp_req` falls, the state returns to RUN with `unclamp_ack`, both inhibits and the status bits [5:4] at 0.
- R10: While `por_n` is 0, the retained flags, inhibits, clamps and error bit keep their values. The state goes to CLAMPED_RUN if any cache is retained and to RUN otherwise, with `pwr_req`=1 and `core_rst_n`=1.
- R11: `pd_req` is ignored in every state other than RUN.
- R12: Status layout: bits [3:0] hold the state code, bit 4 the L2-retained flag, bit 5 the L1-data-retained flag and bit 6 the sticky error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aon_rst_n | input | 1 | Always-on domain reset, active low, asynchronous |
| por_n | input | 1 | Core power-on reset, active low, synchronous, spares retention state |
| pd_req | input | 1 | Power-down request pulse |
| pd_mode | input | 2 | Retention mode: 0 none, 1 L2, 2 L1 data plus L2, 3 L1 data only |
| wake_req | input | 1 | Power-up request while powered off |
| pwr_ack | input | 1 | Power-good acknowledge from the core power switch |
| unclamp_req | input | 1 | Software request to lift the RAM input clamps |
| pwr_req | output | 1 | Core power switch enable |
| core_rst_n | output | 1 | Core reset, active low |
| l1d_rst_inhibit | output | 1 | Suppress hardware reset of the L1 data arrays |
| l2_rst_inhibit | output | 1 | Suppress hardware reset of the L2 arrays |
| l1d_clamp | output | 1 | Hold L1 data RAM inputs at safe values |
| l2_clamp | output | 1 | Hold L2 RAM inputs at safe values |
| l1i_hw_clr | output | 1 | L1 instruction array clear strobe |
| l1d_hw_clr | output | 1 | L1 data array clear strobe |
| l2_hw_clr | output | 1 | L2 array clear strobe |
| unclamp_ack | output | 1 | Confirmation that the clamps are off |
| status | output | 7 | State code, retained flags, sticky error |

## Verification
The bench runs every retention mode through a full power cycle and checks the exact cycle of each step. An inhibit raised late, or a reset asserted together with the power-off, would leave retained data exposed to the reset and clear strobes. It counts the reset-hold window cycle by cycle, so an off-by-one counter shows up as 15 or 17. It issues the illegal L1-only request and checks that a design accepting it reports clamps with no L2 retention. It pulses the power-on reset while clamps are held, and then in RUN. A design that reset the retention flags would drop the clamps and lose the error bit there.

// File: rtl/retn_pwr_pkg.sv
package retn_pwr_pkg;

    typedef enum logic [3:0] {
        ST_RUN      = 4'd0,
        ST_CLAMP    = 4'd1,
        ST_RST_ON   = 4'd2,
        ST_PWR_OFF  = 4'd3,
        ST_PWR_UP   = 4'd4,
        ST_RST_HOLD = 4'd5,
        ST_CLAMPED  = 4'd6,
        ST_UNCLAMP  = 4'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        RM_NONE = 2'd0,
        RM_L2   = 2'd1,
        RM_L1L2 = 2'd2,
        RM_L1   = 2'd3
    } ret_mode_e;

    typedef struct packed {
        logic l1d;
        logic l2;
    } ret_pair_t;

    localparam int STATUS_W = 7;

endpackage

// File: rtl/retn_req_check.sv
module retn_req_check
    import retn_pwr_pkg::*;
#(
    parameter bit L2_ZERO = 1'b0
) (
    input  logic [1:0] mode,
    output logic       legal,
    output ret_pair_t  keep
);

    logic l1_only_ok;

    generate
        if (L2_ZERO) begin : g_no_l2
            assign l1_only_ok = 1'b1;
        end else begin : g_with_l2
            assign l1_only_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        legal = 1'b1;
        keep  = '0;
        case (ret_mode_e'(mode))
            RM_NONE: keep = '0;
            RM_L2:   keep.l2 = 1'b1;
            RM_L1L2: begin
                keep.l1d = 1'b1;
                keep.l2  = 1'b1;
            end
            RM_L1: begin
                legal    = l1_only_ok;
                keep.l1d = l1_only_ok;
            end
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/retn_hold_cnt.sv
module retn_hold_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);

    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = en && (cnt_q == LAST);

endmodule

// File: rtl/retn_pwr_seq.sv
module retn_pwr_seq
    import retn_pwr_pkg::*;
#(
    parameter int RST_HOLD = 16,
    parameter bit L2_ZERO  = 1'b0
) (
    input  logic                clk,
    input  logic                aon_rst_n,
    input  logic                por_n,
    input  logic                pd_req,
    input  logic [1:0]          pd_mode,
    input  logic                wake_req,
    input  logic                pwr_ack,
    input  logic                unclamp_req,
    output logic                pwr_req,
    output logic                core_rst_n,
    output logic                l1d_rst_inhibit,
    output logic                l2_rst_inhibit,
    output logic                l1d_clamp,
    output logic                l2_clamp,
    output logic                l1i_hw_clr,
    output logic                l1d_hw_clr,
    output logic                l2_hw_clr,
    output logic                unclamp_ack,
    output logic [STATUS_W-1:0] status
);

    typedef struct packed {
        seq_state_e state;
        ret_pair_t  kept;
        ret_pair_t  inh;
        ret_pair_t  clamp;
        logic       pwr_on;
        logic       rst_act;
        logic       ack;
        logic       err;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        state:   ST_RUN,
        kept:    '0,
        inh:     '0,
        clamp:   '0,
        pwr_on:  1'b1,
        rst_act: 1'b0,
        ack:     1'b0,
        err:     1'b0
    };

    seq_regs_t seq_d, seq_q;
    logic      req_legal;
    ret_pair_t req_keep;
    logic      hold_done;
    logic      in_hold;
    logic      any_kept;

    retn_req_check #(.L2_ZERO(L2_ZERO)) u_check (
        .mode  (pd_mode),
        .legal (req_legal),
        .keep  (req_keep)
    );

    assign in_hold = (seq_q.state == ST_RST_HOLD);

    retn_hold_cnt #(.LIMIT(RST_HOLD)) u_hold (
        .clk   (clk),
        .rst_n (aon_rst_n),
        .clr   (!in_hold),
        .en    (in_hold),
        .done  (hold_done)
    );

    assign any_kept = seq_q.kept.l1d | seq_q.kept.l2;

    always_comb begin
        seq_d = seq_q;
        if (!por_n) begin
            seq_d.state   = any_kept ? ST_CLAMPED : ST_RUN;
            seq_d.pwr_on  = 1'b1;
            seq_d.rst_act = 1'b0;
            seq_d.ack     = 1'b0;
        end else begin
            case (seq_q.state)
                ST_RUN: begin
                    if (pd_req) begin
                        if (req_legal) begin
                            seq_d.state = ST_CLAMP;
                            seq_d.kept  = req_keep;
                            seq_d.inh   = req_keep;
                            seq_d.clamp = req_keep;
                        end else begin
                            seq_d.err = 1'b1;
                        end
                    end
                end
                ST_CLAMP: begin
                    seq_d.state   = ST_RST_ON;
                    seq_d.rst_act = 1'b1;
                end
                ST_RST_ON: begin
                    seq_d.state  = ST_PWR_OFF;
                    seq_d.pwr_on = 1'b0;
                end
                ST_PWR_OFF: begin
                    if (!pwr_ack && wake_req) begin
                        seq_d.state  = ST_PWR_UP;
                        seq_d.pwr_on = 1'b1;
                    end
                end
                ST_PWR_UP: begin
                    if (pwr_ack) begin
                        seq_d.state = ST_RST_HOLD;
                    end
                end
                ST_RST_HOLD: begin
                    if (hold_done) begin
                        seq_d.rst_act = 1'b0;
                        seq_d.state   = any_kept ? ST_CLAMPED : ST_RUN;
                    end
                end
                ST_CLAMPED: begin
                    if (unclamp_req) begin
                        seq_d.state = ST_UNCLAMP;
                        seq_d.clamp = '0;
                        seq_d.ack   = 1'b1;
                    end
                end
                ST_UNCLAMP: begin
                    if (!unclamp_req) begin
                        seq_d.state = ST_RUN;
                        seq_d.ack   = 1'b0;
                        seq_d.inh   = '0;
                        seq_d.kept  = '0;
                    end
                end
                default: seq_d.state = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge aon_rst_n) begin
        if (!aon_rst_n) begin
            seq_q <= REGS_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pwr_req         = seq_q.pwr_on;
    assign core_rst_n      = !seq_q.rst_act;
    assign l1d_rst_inhibit = seq_q.inh.l1d;
    assign l2_rst_inhibit  = seq_q.inh.l2;
    assign l1d_clamp       = seq_q.clamp.l1d;
    assign l2_clamp        = seq_q.clamp.l2;
    assign l1i_hw_clr      = in_hold;
    assign l1d_hw_clr      = in_hold && !seq_q.inh.l1d;
    assign l2_hw_clr       = in_hold && !seq_q.inh.l2;
    assign unclamp_ack     = seq_q.ack;
    assign status          = {seq_q.err, seq_q.kept.l1d, seq_q.kept.l2, seq_q.state};

endmodule

// File: rtl/retn_pwr_chk.sv
module retn_pwr_chk #(
    parameter bit L2_ZERO = 1'b0
) (
    input logic       clk,
    input logic       aon_rst_n,
    input logic       pwr_req,
    input logic       pwr_ack,
    input logic       core_rst_n,
    input logic       l1d_rst_inhibit,
    input logic       l2_rst_inhibit,
    input logic       l1d_clamp,
    input logic       l2_clamp,
    input logic       l1i_hw_clr,
    input logic       l2_hw_clr,
    input logic       l1d_hw_clr,
    input logic       unclamp_ack
);

    // R2
    inhibit_before_reset_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
        $fell(core_rst_n) |-> ($stable(l1d_rst_inhibit) && $stable(l2_rst_inhibit)));

    // R3
    reset_before_power_off_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
        $fell(pwr_req) |-> (!core_rst_n && $past(!core_rst_n)));

    // R4
    no_l1_only_clamp_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (l1d_clamp && !L2_ZERO) |-> l2_clamp);

    // R6
    release_after_power_good_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
        $rose(core_rst_n) |-> pwr_ack);

    // R7
    icache_cleared_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
        $rose(core_rst_n) |-> $past(l1i_hw_clr));

    // R7
    retained_not_cleared_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (l2_hw_clr |-> !l2_rst_inhibit) and (l1d_hw_clr |-> !l1d_rst_inhibit));

    // R8
    clamp_while_off_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (!pwr_ack && l2_rst_inhibit) |-> l2_clamp);

    // R9
    ack_only_unclamped_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
        unclamp_ack |-> (!l1d_clamp && !l2_clamp));

endmodule

bind retn_pwr_seq retn_pwr_chk #(.L2_ZERO(L2_ZERO)) u_chk (
    .clk             (clk),
    .aon_rst_n       (aon_rst_n),
    .pwr_req         (pwr_req),
    .pwr_ack         (pwr_ack),
    .core_rst_n      (core_rst_n),
    .l1d_rst_inhibit (l1d_rst_inhibit),
    .l2_rst_inhibit  (l2_rst_inhibit),
    .l1d_clamp       (l1d_clamp),
    .l2_clamp        (l2_clamp),
    .l1i_hw_clr      (l1i_hw_clr),
    .l2_hw_clr       (l2_hw_clr),
    .l1d_hw_clr      (l1d_hw_clr),
    .unclamp_ack     (unclamp_ack)
);

// File: tb/sim_retn_pwr_seq.sv
module sim_retn_pwr_seq;

    localparam int HOLD = 16;

    logic       clk = 1'b0;
    logic       aon_rst_n = 1'b0;
    logic       por_n = 1'b1;
    logic       pd_req = 1'b0;
    logic [1:0] pd_mode = 2'd0;
    logic       wake_req = 1'b0;
    logic       pwr_ack;
    logic       unclamp_req = 1'b0;
    logic       pwr_req, core_rst_n, l1d_rst_inhibit, l2_rst_inhibit;
    logic       l1d_clamp, l2_clamp, l1i_hw_clr, l1d_hw_clr, l2_hw_clr, unclamp_ack;
    logic [6:0] status;
    logic [2:0] ack_sh;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk or negedge aon_rst_n) begin
        if (!aon_rst_n) ack_sh <= 3'b111;
        else            ack_sh <= {ack_sh[1:0], pwr_req};
    end
    assign pwr_ack = ack_sh[2];

    retn_pwr_seq #(.RST_HOLD(HOLD), .L2_ZERO(1'b0)) u0 (
        .clk(clk), .aon_rst_n(aon_rst_n), .por_n(por_n), .pd_req(pd_req),
        .pd_mode(pd_mode), .wake_req(wake_req), .pwr_ack(pwr_ack),
        .unclamp_req(unclamp_req), .pwr_req(pwr_req), .core_rst_n(core_rst_n),
        .l1d_rst_inhibit(l1d_rst_inhibit), .l2_rst_inhibit(l2_rst_inhibit),
        .l1d_clamp(l1d_clamp), .l2_clamp(l2_clamp), .l1i_hw_clr(l1i_hw_clr),
        .l1d_hw_clr(l1d_hw_clr), .l2_hw_clr(l2_hw_clr),
        .unclamp_ack(unclamp_ack), .status(status)
    );

    // {mode[1:0], keep_l1d, keep_l2, err_after}
    localparam logic [4:0] VEC [4] = '{
        5'b00_00_0,
        5'b01_01_0,
        5'b11_00_1,
        5'b10_11_1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_state(input logic [3:0] s);
        for (int i = 0; i < 40 && status[3:0] != s; i++) step();
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic power_cycle(input logic [1:0] m, input logic el1, input logic el2);
        int hold_n;
        pd_mode = m;
        pd_req = 1'b1;
        step();
        pd_req = 1'b0;
        chk("R2 state", status[3:0], 4'd1);
        chk("R2 inhibits", {l1d_rst_inhibit, l2_rst_inhibit}, {el1, el2});
        chk("R2 clamps", {l1d_clamp, l2_clamp}, {el1, el2});
        chk("R2 reset not yet", core_rst_n, 1'b1);
        chk("R12 kept bits", status[5:4], {el1, el2});
        step();
        chk("R3 reset state", status[3:0], 4'd2);
        chk("R3 core reset", {core_rst_n, pwr_req}, 2'b01);
        step();
        chk("R3 power off", {status[3:0], pwr_req}, {4'd3, 1'b0});
        pd_req = 1'b1;
        step();
        pd_req = 1'b0;
        chk("R11 ignored in power off", status[3:0], 4'd3);
        repeat (4) step();
        chk("R5 no wake stays off", {status[3:0], pwr_req}, {4'd3, 1'b0});
        wake_req = 1'b1;
        wait_state(4'd4);
        wake_req = 1'b0;
        chk("R5 power up", {status[3:0], pwr_req}, {4'd4, 1'b1});
        chk("R5 ack low at entry", pwr_ack, 1'b0);
        wait_state(4'd5);
        chk("R5 ack seen", pwr_ack, 1'b1);
        hold_n = 0;
        while (status[3:0] == 4'd5 && hold_n < 40) begin
            chk("R6 reset held", core_rst_n, 1'b0);
            chk("R7 clear strobes", {l1i_hw_clr, l1d_hw_clr, l2_hw_clr}, {1'b1, !el1, !el2});
            hold_n++;
            step();
        end
        chk("R6 hold length", hold_n, HOLD);
        chk("R6 reset released", core_rst_n, 1'b1);
        chk("R7 strobes off", {l1i_hw_clr, l1d_hw_clr, l2_hw_clr}, 3'b000);
        chk("R8 post state", status[3:0], (el1 | el2) ? 4'd6 : 4'd0);
        chk("R8 clamps kept", {l1d_clamp, l2_clamp, l1d_rst_inhibit, l2_rst_inhibit},
            {el1, el2, el1, el2});
    endtask

    task automatic release_clamps();
        repeat (3) step();
        chk("R9 waits for request", {status[3:0], unclamp_ack}, {4'd6, 1'b0});
        unclamp_req = 1'b1;
        step();
        chk("R9 unclamp", {status[3:0], l1d_clamp, l2_clamp, unclamp_ack}, {4'd7, 3'b001});
        step();
        chk("R9 ack held", unclamp_ack, 1'b1);
        unclamp_req = 1'b0;
        step();
        chk("R9 back to run", {status[5:0], unclamp_ack, l1d_rst_inhibit, l2_rst_inhibit},
            {6'd0, 3'b000});
    endtask

    initial begin
        repeat (3) step();
        aon_rst_n = 1'b1;
        repeat (4) step();
        chk("R1 status", status, 7'd0);
        chk("R1 power and reset", {pwr_req, core_rst_n}, 2'b11);
        chk("R1 side outputs", {l1d_rst_inhibit, l2_rst_inhibit, l1d_clamp, l2_clamp,
            l1i_hw_clr, l1d_hw_clr, l2_hw_clr, unclamp_ack}, 8'd0);

        foreach (VEC[i]) begin
            logic [1:0] m;
            m = VEC[i][4:3];
            if (m == 2'd3) begin
                pd_mode = m;
                pd_req = 1'b1;
                step();
                pd_req = 1'b0;
                chk("R4 rejected stays run", status[3:0], 4'd0);
                chk("R4 no clamp or inhibit", {l1d_clamp, l2_clamp, l1d_rst_inhibit, l2_rst_inhibit}, 4'd0);
                repeat (2) step();
                chk("R4 still run", {status[3:0], pwr_req, core_rst_n}, {4'd0, 2'b11});
            end else begin
                power_cycle(m, VEC[i][2], VEC[i][1]);
                if (VEC[i][2] | VEC[i][1]) release_clamps();
            end
            chk("R4 sticky error", status[6], VEC[i][0]);
        end

        power_cycle(2'd1, 1'b0, 1'b1);
        por_n = 1'b0;
        step();
        step();
        chk("R10 state under por", status[3:0], 4'd6);
        chk("R10 retention kept", {status[6:4], l2_clamp, l2_rst_inhibit}, 5'b10111);
        chk("R10 core up", {pwr_req, core_rst_n}, 2'b11);
        por_n = 1'b1;
        step();
        pd_mode = 2'd0;
        pd_req = 1'b1;
        step();
        pd_req = 1'b0;
        chk("R11 ignored in clamped run", status[3:0], 4'd6);
        release_clamps();

        por_n = 1'b0;
        step();
        chk("R10 por in run", {status, pwr_req, core_rst_n}, {7'h40, 2'b11});
        por_n = 1'b1;
        step();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

endmodule